// File: doc/BRIEF.md
# NOR flash command state machine

This block is the device-side command interpreter of a parallel NOR-style flash. It watches single-cycle bus writes, each carrying an address and a data byte. It recognises coded multi-write sequences and runs the embedded operations they start: a word program and a whole-array erase. Both are timed by cycle counters in place of cell physics. A small register array holds the contents, so that every effect can be read back through the normal read port. While an operation runs, a read returns a status word instead of array data. A running program can be paused and resumed with one-write commands.

The control FSM has six states. `S_READ` is the idle state, in which reads return array data and the unlock decoder is active. `S_PROG` is a running program. `S_PSWAIT` is a program that keeps running while the suspend delay counts down. `S_PSUSP` is a paused program. `S_ERPRE` is the erase phase that drives every word to zero. `S_ERMAIN` is the phase that sets every word to all ones.

The transitions are named as follows:
- accept-program: `S_READ`→`S_PROG`.
- accept-erase: `S_READ`→`S_ERPRE`.
- suspend-request: `S_PROG`→`S_PSWAIT`.
- suspend-land: `S_PSWAIT`→`S_PSUSP`.
- resume: `S_PSUSP`→`S_PROG`.
- program-finish: `S_PROG` or `S_PSWAIT` → `S_READ`.
- preprogram-end: `S_ERPRE`→`S_ERMAIN`.
- erase-finish: `S_ERMAIN`→`S_READ`.

Top module: `nor_flash_csm`

## Requirements
- R1: After reset every array word reads FFh, `rdata_o` is 00h and `done_o` is low.
- R2: Writing AAh@555h, 55h@2AAh, A0h@555h and then data D at address A programs word A. The new value is the old value AND D, so bits only go from 1 to 0. `done_o` rises exactly PROG_CYC cycles after the clock edge that takes the fourth write.
- R3: Writing AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and 10h@555h erases the whole array. The array is first driven to all zeros and then to all ones. `done_o` rises PRE_CYC+ERASE_CYC cycles after the sixth write, and every word then reads FFh.
- R4: A write that does not match the expected step of a sequence returns the decoder to its first step. The aborted sequence changes nothing, and a later complete sequence works normally.
- R5: During a program, a read returns a status word. Bit 7 is the inverse of bit 7 of the data being programmed. Bit 6 is 0 on the first read after the start and inverts on each later read. All other bits are 0.
- R6: During an erase, a read returns a status word. Bit 7 is 0. Bits 6 and 2 are both 0 on the first read after the start and both invert on each later read. All other bits are 0.
- R7: Writing B0h to any address during `S_PROG` requests a suspend. The pause takes effect SUSP_LAT cycles after that write, and reads before that still return status.
- R8: While the program is paused, a read of the sector being programmed returns the program status word, and reads of other sectors return array data. The sector is address bits [ARR_AW-1:ARR_AW-SECT_BITS]. The program's remaining time does not advance while paused.
- R9: Writing 30h to any address while paused resumes the program with its remaining time. 30h written while the program runs is ignored. A new B0h after the resume is accepted again.
- R10: If the program's time runs out inside the suspend delay, the program completes, `done_o` pulses at the normal time and the suspend is dropped.
- R11: B0h and 30h writes in read mode or during an erase have no effect. B0h written while paused has no effect.
- R12: `done_o` is a single-cycle pulse, raised on each return to read mode from a program or an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Bus write strobe, one write per high cycle |
| rd_i | input | 1 | Bus read strobe; `rdata_o` updates on that edge |
| addr_i | input | BUS_AW | Bus address for reads and writes |
| wdata_i | input | DW | Bus write data |
| rdata_o | output | DW | Registered read data or status word |
| done_o | output | 1 | One-cycle pulse when an operation ends |

## Verification
The two functions that can fall in the same cycle are the expiry of a program's time and the expiry of the suspend delay. When both are due, completion must win. The bench provokes this by writing B0h three cycles before the program would end, so the delay is still counting when the program runs out. It judges the result by the exact cycle on which `done_o` rises and by reading back the programmed word. A companion case pauses a program twice and checks that the completion cycle equals the sum of the running intervals only.

// File: rtl/nor_csm_pkg.sv
package nor_csm_pkg;

    typedef enum logic [2:0] {
        S_READ,
        S_PROG,
        S_PSWAIT,
        S_PSUSP,
        S_ERPRE,
        S_ERMAIN
    } csm_state_e;

    localparam logic [11:0] A_KEY1   = 12'h555;
    localparam logic [11:0] A_KEY2   = 12'h2AA;
    localparam logic [7:0]  D_KEY1   = 8'hAA;
    localparam logic [7:0]  D_KEY2   = 8'h55;
    localparam logic [7:0]  D_PROG   = 8'hA0;
    localparam logic [7:0]  D_ESETUP = 8'h80;
    localparam logic [7:0]  D_CHIP   = 8'h10;
    localparam logic [7:0]  D_PAUSE  = 8'hB0;
    localparam logic [7:0]  D_RESUME = 8'h30;

endpackage

// File: rtl/nor_cmd_decode.sv
module nor_cmd_decode
    import nor_csm_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    input  logic          seq_en_i,
    output logic          prog_go_o,
    output logic          erase_go_o,
    output logic          pause_hit_o,
    output logic          resume_hit_o
);

    logic [2:0] step, step_nxt;
    logic       at_k1, at_k2;

    always_comb begin
        at_k1 = (addr_i[11:0] == A_KEY1);
        at_k2 = (addr_i[11:0] == A_KEY2);
    end

    always_comb begin
        prog_go_o    = we_i && seq_en_i && (step == 3'd3);
        erase_go_o   = we_i && seq_en_i && (step == 3'd6) && at_k1 && (wdata_i == D_CHIP);
        pause_hit_o  = we_i && (step == 3'd0) && (wdata_i == D_PAUSE);
        resume_hit_o = we_i && (step == 3'd0) && (wdata_i == D_RESUME);
    end

    always_comb begin
        step_nxt = step;
        if (!seq_en_i) begin
            step_nxt = 3'd0;
        end else if (we_i) begin
            unique case (step)
                3'd0: step_nxt = (at_k1 && wdata_i == D_KEY1) ? 3'd1 : 3'd0;
                3'd1: step_nxt = (at_k2 && wdata_i == D_KEY2) ? 3'd2 : 3'd0;
                3'd2: begin
                    if (at_k1 && wdata_i == D_PROG)
                        step_nxt = 3'd3;
                    else if (at_k1 && wdata_i == D_ESETUP)
                        step_nxt = 3'd4;
                    else
                        step_nxt = 3'd0;
                end
                3'd4: step_nxt = (at_k1 && wdata_i == D_KEY1) ? 3'd5 : 3'd0;
                3'd5: step_nxt = (at_k2 && wdata_i == D_KEY2) ? 3'd6 : 3'd0;
                default: step_nxt = 3'd0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step <= 3'd0;
        else        step <= step_nxt;
    end

    // R4: an unmatched write in the first steps always falls back to step 0
    p_abort_to_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en_i && we_i && step == 3'd1 && !(at_k2 && wdata_i == D_KEY2)) |=> step == 3'd0);

endmodule

// File: rtl/nor_cell_array.sv
module nor_cell_array #(
    parameter int ARR_AW = 5,
    parameter int DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en_i,
    input  logic [ARR_AW-1:0] prog_addr_i,
    input  logic [DW-1:0]     prog_data_i,
    input  logic              zero_all_i,
    input  logic              fill_all_i,
    input  logic [ARR_AW-1:0] rd_addr_i,
    output logic [DW-1:0]     rd_word_o
);

    localparam int DEPTH = 1 << ARR_AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (fill_all_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (zero_all_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (prog_en_i) begin
            mem[prog_addr_i] <= mem[prog_addr_i] & prog_data_i;
        end
    end

    assign rd_word_o = mem[rd_addr_i];

    // R2: programming may only clear bits that are zero in the supplied data
    p_prog_clears_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en_i && !zero_all_i && !fill_all_i)
        |=> ((mem[$past(prog_addr_i)] & ~$past(prog_data_i)) == '0));

endmodule

// File: rtl/nor_status.sv
module nor_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic          start_i,
    input  logic          stat_sel_i,
    input  logic          erase_i,
    input  logic          final_b7_i,
    input  logic [DW-1:0] arr_i,
    output logic [DW-1:0] rdata_o
);

    logic          tog6, tog2;
    logic [DW-1:0] stat_word;

    always_comb begin
        stat_word    = '0;
        stat_word[7] = ~final_b7_i;
        stat_word[6] = tog6;
        stat_word[2] = erase_i ? tog2 : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
            tog6    <= 1'b0;
            tog2    <= 1'b0;
        end else if (start_i) begin
            tog6 <= 1'b0;
            tog2 <= 1'b0;
        end else if (rd_i) begin
            if (stat_sel_i) begin
                rdata_o <= stat_word;
                tog6    <= ~tog6;
                if (erase_i) tog2 <= ~tog2;
            end else begin
                rdata_o <= arr_i;
            end
        end
    end

    // R5: consecutive status reads invert bit 6
    p_dq6_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && stat_sel_i && !start_i) |=> (tog6 != $past(tog6)));

endmodule

// File: rtl/nor_flash_csm.sv
module nor_flash_csm
    import nor_csm_pkg::*;
#(
    parameter int BUS_AW    = 12,
    parameter int ARR_AW    = 5,
    parameter int SECT_BITS = 2,
    parameter int DW        = 8,
    parameter int PROG_CYC  = 40,
    parameter int PRE_CYC   = 20,
    parameter int ERASE_CYC = 30,
    parameter int SUSP_LAT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              rd_i,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              done_o
);

    localparam int MAX_A   = (PROG_CYC > PRE_CYC) ? PROG_CYC : PRE_CYC;
    localparam int CNT_TOP = (MAX_A > ERASE_CYC) ? MAX_A : ERASE_CYC;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam int SW      = $clog2(SUSP_LAT + 1);

    csm_state_e        state, state_nxt;
    logic [CW-1:0]     cnt;
    logic [SW-1:0]     scnt;
    logic [ARR_AW-1:0] tgt_addr;
    logic [DW-1:0]     tgt_data;

    logic prog_go, erase_go, pause_hit, resume_hit;
    logic start, commit, zero_all, fill_all, finish;
    logic same_sect, stat_sel, in_erase;
    logic [DW-1:0] arr_word;

    nor_cmd_decode #(.AW(BUS_AW)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .we_i         (we_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i[7:0]),
        .seq_en_i     (state == S_READ),
        .prog_go_o    (prog_go),
        .erase_go_o   (erase_go),
        .pause_hit_o  (pause_hit),
        .resume_hit_o (resume_hit)
    );

    nor_cell_array #(.ARR_AW(ARR_AW), .DW(DW)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_en_i   (commit),
        .prog_addr_i (tgt_addr),
        .prog_data_i (tgt_data),
        .zero_all_i  (zero_all),
        .fill_all_i  (fill_all),
        .rd_addr_i   (addr_i[ARR_AW-1:0]),
        .rd_word_o   (arr_word)
    );

    nor_status #(.DW(DW)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (rd_i),
        .start_i    (start),
        .stat_sel_i (stat_sel),
        .erase_i    (in_erase),
        .final_b7_i (in_erase ? 1'b1 : tgt_data[7]),
        .arr_i      (arr_word),
        .rdata_o    (rdata_o)
    );

    // next-state and control strobes
    always_comb begin
        state_nxt = state;
        start     = 1'b0;
        commit    = 1'b0;
        zero_all  = 1'b0;
        fill_all  = 1'b0;
        finish    = 1'b0;
        unique case (state)
            S_READ: begin
                if (prog_go) begin
                    state_nxt = S_PROG;
                    start     = 1'b1;
                end else if (erase_go) begin
                    state_nxt = S_ERPRE;
                    start     = 1'b1;
                end
            end
            S_PROG: begin
                if (cnt == CW'(1)) begin
                    state_nxt = S_READ;
                    commit    = 1'b1;
                    finish    = 1'b1;
                end else if (pause_hit) begin
                    state_nxt = S_PSWAIT;
                end
            end
            S_PSWAIT: begin
                if (cnt == CW'(1)) begin
                    state_nxt = S_READ;
                    commit    = 1'b1;
                    finish    = 1'b1;
                end else if (scnt == SW'(1)) begin
                    state_nxt = S_PSUSP;
                end
            end
            S_PSUSP: begin
                if (resume_hit) state_nxt = S_PROG;
            end
            S_ERPRE: begin
                if (cnt == CW'(1)) begin
                    state_nxt = S_ERMAIN;
                    zero_all  = 1'b1;
                end
            end
            S_ERMAIN: begin
                if (cnt == CW'(1)) begin
                    state_nxt = S_READ;
                    fill_all  = 1'b1;
                    finish    = 1'b1;
                end
            end
            default: state_nxt = S_READ;
        endcase
    end

    always_comb begin
        in_erase  = (state == S_ERPRE) || (state == S_ERMAIN);
        same_sect = (tgt_addr[ARR_AW-1 -: SECT_BITS] == addr_i[ARR_AW-1 -: SECT_BITS]);
        stat_sel  = (state == S_PROG) || (state == S_PSWAIT) || in_erase
                    || ((state == S_PSUSP) && same_sect);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_READ;
        else        state <= state_nxt;
    end

    // counters, latched target and done pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            scnt     <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= finish;
            if (start) begin
                if (prog_go) begin
                    cnt      <= CW'(PROG_CYC);
                    tgt_addr <= addr_i[ARR_AW-1:0];
                    tgt_data <= wdata_i;
                end else begin
                    cnt <= CW'(PRE_CYC);
                end
            end else begin
                unique case (state)
                    S_PROG, S_PSWAIT, S_ERMAIN: cnt <= cnt - CW'(1);
                    S_ERPRE: cnt <= (cnt == CW'(1)) ? CW'(ERASE_CYC) : cnt - CW'(1);
                    default: cnt <= cnt;
                endcase
            end
            if (state == S_PROG && pause_hit && cnt != CW'(1))
                scnt <= SW'(SUSP_LAT);
            else if (state == S_PSWAIT)
                scnt <= scnt - SW'(1);
        end
    end

    // R8: remaining program time is frozen while paused
    p_freeze_in_pause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PSUSP) |=> $stable(cnt));

    // R7: the suspend delay ends in the pause or in completion, never back in plain run
    p_wait_exits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PSWAIT) |=> (state != S_PROG));

    // R10: completion wins over the end of the suspend delay
    p_finish_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PSWAIT && cnt == CW'(1)) |=> (state == S_READ && done_o));

    // R11: pause and resume writes leave a running erase alone
    p_erase_deaf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_erase && (pause_hit || resume_hit)) |=> (state == S_ERPRE || state == S_ERMAIN || state == S_READ));

    // R12: done is a one-cycle pulse
    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/nor_flash_csm_tb.sv
`timescale 1ns/1ps
module nor_flash_csm_tb_top;

    localparam int PC = 40;
    localparam int PRE = 20;
    localparam int ER = 30;
    localparam int SL = 8;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_WT = 2'd2;
    localparam int NV = 33;

    // {op, requirement number, address, data or expected read}
    localparam logic [25:0] VEC [NV] = '{
        {OP_RD, 4'd1, 12'h000, 8'hFF},   // R1 erased after reset
        {OP_RD, 4'd1, 12'h01F, 8'hFF},   // R1
        {OP_WR, 4'd2, 12'h555, 8'hAA},   // R2 program 005 <= 5A
        {OP_WR, 4'd2, 12'h2AA, 8'h55},
        {OP_WR, 4'd2, 12'h555, 8'hA0},
        {OP_WR, 4'd2, 12'h005, 8'h5A},
        {OP_WT, 4'd2, 12'h000, 8'h00},
        {OP_RD, 4'd2, 12'h005, 8'h5A},
        {OP_WR, 4'd2, 12'h555, 8'hAA},   // R2 reprogram 005 with F0 -> 50
        {OP_WR, 4'd2, 12'h2AA, 8'h55},
        {OP_WR, 4'd2, 12'h555, 8'hA0},
        {OP_WR, 4'd2, 12'h005, 8'hF0},
        {OP_WT, 4'd2, 12'h000, 8'h00},
        {OP_RD, 4'd2, 12'h005, 8'h50},
        {OP_WR, 4'd4, 12'h555, 8'hAA},   // R4 bad data in second write
        {OP_WR, 4'd4, 12'h2AA, 8'h56},
        {OP_WR, 4'd4, 12'h555, 8'hA0},
        {OP_WR, 4'd4, 12'h006, 8'h00},
        {OP_RD, 4'd4, 12'h006, 8'hFF},
        {OP_WR, 4'd4, 12'h555, 8'hAA},   // R4 bad address in second write
        {OP_WR, 4'd4, 12'h2AB, 8'h55},
        {OP_WR, 4'd4, 12'h555, 8'hAA},   // R4 full sequence recovers
        {OP_WR, 4'd4, 12'h2AA, 8'h55},
        {OP_WR, 4'd4, 12'h555, 8'hA0},
        {OP_WR, 4'd4, 12'h007, 8'h33},
        {OP_WT, 4'd4, 12'h000, 8'h00},
        {OP_RD, 4'd4, 12'h007, 8'h33},
        {OP_WR, 4'd11, 12'h123, 8'hB0},  // R11 pause in read mode
        {OP_WR, 4'd11, 12'h123, 8'h30},  // R11 resume in read mode
        {OP_RD, 4'd11, 12'h005, 8'h50},
        {OP_RD, 4'd11, 12'h007, 8'h33},
        {OP_RD, 4'd11, 12'h006, 8'hFF},
        {OP_RD, 4'd1, 12'h01F, 8'hFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [11:0] addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        done_o;

    int nchk = 0;
    int nerr = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nor_flash_csm #(
        .PROG_CYC(PC), .PRE_CYC(PRE), .ERASE_CYC(ER), .SUSP_LAT(SL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .we_i(we_i), .rd_i(rd_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .done_o(done_o)
    );

    task automatic chk8(input string req, input logic [7:0] got, input logic [7:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chki(input string req, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        we_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk);
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] v);
        rd_i = 1'b1; addr_i = a;
        @(posedge clk);
        @(negedge clk);
        v = rdata_o;
        rd_i = 1'b0;
    endtask

    task automatic wait_done(input string req, output int at);
        bit seen = 0;
        at = -1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (done_o) begin seen = 1; at = cyc; break; end
        end
        if (!seen) begin
            nchk++; nerr++;
            $display("FAIL %s: done never rose, got 0 expected 1", req);
        end
    endtask

    task automatic prog_seq(input logic [11:0] a, input logic [7:0] d);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'hA0); wr(a, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int e, es, er, es2, er2, at, rem1, rem2, nstat;
        bit gotd;

        repeat (3) @(negedge clk);
        chk8("R1 rdata at reset", rdata_o, 8'h00);
        chk8("R1 done at reset", {7'd0, done_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [11:0] a;
            logic [7:0]  d;
            {op, rq, a, d} = VEC[i];
            if (op == OP_WR) begin
                wr(a, d);
            end else if (op == OP_RD) begin
                rd(a, v);
                chk8($sformatf("R%0d vector %0d", rq, i), v, d);
            end else begin
                wait_done($sformatf("R%0d vector %0d", rq, i), at);
            end
        end

        // R5 program status and R2 timing, R12 pulse width
        prog_seq(12'h010, 8'h12);
        e = cyc;
        rd(12'h010, v); chk8("R5 status read 1", v, 8'h80);
        rd(12'h001, v); chk8("R5 status read 2", v, 8'hC0);
        rd(12'h01F, v); chk8("R5 status read 3", v, 8'h80);
        wait_done("R2", at);
        chki("R2 program duration", at, e + PC);
        @(negedge clk);
        chk8("R12 done width", {7'd0, done_o}, 8'h00);
        rd(12'h010, v); chk8("R2 readback", v, 8'h12);

        // R6 erase status, R11 ignored pause/resume, R3 result and timing
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
        wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h10);
        e = cyc;
        rd(12'h000, v); chk8("R6 status read 1", v, 8'h00);
        rd(12'h015, v); chk8("R6 status read 2", v, 8'h44);
        rd(12'h00A, v); chk8("R6 status read 3", v, 8'h00);
        wr(12'h555, 8'hB0);
        wr(12'h000, 8'h30);
        wait_done("R3", at);
        chki("R3 R11 erase duration", at, e + PRE + ER);
        @(negedge clk);
        chk8("R12 done width after erase", {7'd0, done_o}, 8'h00);
        rd(12'h005, v); chk8("R3 erased 005", v, 8'hFF);
        rd(12'h010, v); chk8("R3 erased 010", v, 8'hFF);

        // reference word in sector 3
        prog_seq(12'h018, 8'h5A);
        wait_done("R2", at);

        // R7 R8 R9 suspend and resume, twice
        prog_seq(12'h002, 8'h0F);
        e = cyc;
        repeat (2) @(negedge clk);
        wr(12'h100, 8'h30);                       // R9 ignored while running
        wr(12'h321, 8'hB0);
        es = cyc;
        nstat = 0; gotd = 0;
        for (int k = 0; k < 40 && !gotd; k++) begin
            rd(12'h018, v);
            if (v == 8'h5A) gotd = 1; else nstat++;
        end
        chki("R7 suspend latency", nstat, SL);
        rd(12'h003, v);
        chk8("R8 blocked sector read", v & 8'hBF, 8'h80);
        repeat (6) @(negedge clk);
        wr(12'h000, 8'h30);
        er = cyc;
        rem1 = PC - (es + SL - e);
        wr(12'h000, 8'hB0);                       // R9 new pause accepted
        es2 = cyc;
        nstat = 0; gotd = 0;
        for (int k = 0; k < 40 && !gotd; k++) begin
            rd(12'h01C, v);
            if (v == 8'h5A || v == 8'hFF) gotd = 1; else nstat++;
        end
        chki("R9 second suspend latency", nstat, SL);
        repeat (3) @(negedge clk);
        wr(12'h000, 8'hB0);                       // R11 pause while paused
        wr(12'h000, 8'h30);
        er2 = cyc;
        rem2 = rem1 - (es2 + SL - er);
        wait_done("R8", at);
        chki("R8 R9 paused time not counted", at, er2 + rem2);
        rd(12'h002, v); chk8("R9 readback after resume", v, 8'h0F);

        // R10 program ends inside the suspend delay
        prog_seq(12'h01A, 8'h3C);
        e = cyc;
        repeat (PC - 4) @(negedge clk);
        wr(12'h000, 8'hB0);
        wait_done("R10", at);
        chki("R10 completion time", at, e + PC);
        rd(12'h01A, v); chk8("R10 readback", v, 8'h3C);
        rd(12'h018, v); chk8("R10 read mode restored", v, 8'h5A);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule